// File: doc/BRIEF.md
# Linked-Descriptor DMA Walker

This block moves data between a card-side data FIFO and host memory buffers, with the transfers described by a list of 16-byte descriptors held in host memory. Software writes the list's start address into a base register, turns the engine on through a mode register, and then writes a poll-demand register. The engine fetches each descriptor in turn. Every descriptor gives a control word, a byte count, a buffer address and a link address. The engine moves the buffer's words in the direction given by `xfer_tx`, returns the descriptor to software by writing its control word back, and moves on to the next descriptor.

The walk ends in one of two ways. If the engine reaches a descriptor that software has not handed over, it flags the descriptor as unavailable and suspends until the next poll demand. Otherwise it stops after the descriptor that carries the last-segment flag. Completion is reported through sticky status bits that software clears by writing 1 to them. A control-word flag can suppress the completion report on intermediate descriptors.

The memory side is a single-outstanding word port: the engine holds a request until the memory acknowledges it. The FIFO side has a push port for transmit and a pop port for receive.

Top module: `chain_dma`

## Requirements
- R1: After reset, `dma_busy` is 0, `dma_sts` is 0 and no memory request, FIFO push or FIFO pop is asserted. Register selects are: 0 mode, 1 base, 2 poll demand, 3 status. In the mode register, bit 0 is enable and bit 1 is soft reset.
- R2: A poll-demand write (any data) while enabled and idle starts a walk at the current descriptor pointer. Each descriptor is fetched as four word reads at pointer +0, +4, +8 and +12, in that order.
- R3: A poll-demand write while the enable bit is 0 is ignored: no memory read occurs and `dma_busy` stays 0.
- R4: With `xfer_tx`=1, the engine reads ceil(N/4) words from the buffer at ascending addresses and pushes them into the FIFO in order. N is bits [11:0] of descriptor word 1; the higher bits of that word are ignored.
- R5: With `xfer_tx`=0, the engine pops ceil(N/4) words from the FIFO and writes them to consecutive buffer words. No other buffer word is written.
- R6: After a descriptor's data has moved, its control word is written back to the descriptor address with bit 31 (owned by DMA) cleared and all other bits unchanged.
- R7: The next descriptor address is chosen in this priority order. Control bit 5 (end of ring) set gives the base register. Otherwise control bit 4 (chained) set gives word 3. Otherwise the current address plus 16 is used.
- R8: After a descriptor with control bit 2 (last segment) completes, the engine goes idle with its pointer on the next descriptor, so a later poll continues from there.
- R9: A fetched control word with bit 31 clear sets status bit 2 (descriptor unavailable), moves no data and idles without advancing the pointer, so the next poll refetches the same descriptor.
- R10: Completion sets status bit 0 (transmit) or bit 1 (receive) when a descriptor completes that has bit 2 set or bit 1 (suppress completion) clear. A non-last descriptor with bit 1 set sets no completion bit.
- R11: Writing 1 to a status bit clears it and writing 0 leaves it. Bit 3 reads as the OR of bits 0 and 1.
- R12: A mode write with bit 1 set aborts any transfer at once and clears the status, the enable bit, the base register and the descriptor pointer.
- R13: A descriptor whose byte count is 0 moves no data but is still written back.
- R14: A memory request holds its address and direction until acknowledged. A FIFO push holds its data until accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| xfer_tx | input | 1 | Direction for the next walk: 1 memory to FIFO, 0 FIFO to memory |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 32 | Memory read data, valid with acknowledge |
| fifo_wr_valid | output | 1 | FIFO push valid |
| fifo_wr_ready | input | 1 | FIFO has room |
| fifo_wr_data | output | 32 | FIFO push data |
| fifo_rd_valid | input | 1 | FIFO holds a word |
| fifo_rd_data | input | 32 | FIFO head word |
| fifo_rd_pop | output | 1 | FIFO pop |
| dma_sts | output | 4 | Status: tx done, rx done, unavailable, summary |
| dma_busy | output | 1 | Engine walking a list |

## Verification
Most internal errors surface at the ports within one descriptor. A wrong pointer shows up in the addresses of the next four-word fetch. A wrong word count shows up as extra or missing FIFO beats before the write-back. A lost ownership check shows up as data moved for a descriptor that software never handed over. Status and write-back faults show at the descriptor's end, and a bad next-address choice shows in the very next read. A stuck sequencer leaves `dma_busy` high, which the bench catches with a bounded wait.

// File: rtl/chain_dma_pkg.sv
package chain_dma_pkg;
  // control word bit positions (decoded by software as well)
  localparam int CTL_OWN = 31;
  localparam int CTL_CES = 30;
  localparam int CTL_EOR = 5;
  localparam int CTL_CHN = 4;
  localparam int CTL_FS  = 3;
  localparam int CTL_LS  = 2;
  localparam int CTL_DIC = 1;

  localparam int DESC_BYTES = 16;

  localparam logic [1:0] SEL_MODE = 2'd0;
  localparam logic [1:0] SEL_BASE = 2'd1;
  localparam logic [1:0] SEL_POLL = 2'd2;
  localparam logic [1:0] SEL_STAT = 2'd3;

  localparam int MODE_EN  = 0;
  localparam int MODE_SWR = 1;

  localparam int STS_W = 4;

  typedef enum logic [3:0] {
    WK_IDLE, WK_CTRL, WK_SIZE, WK_BUF, WK_LINK,
    WK_TX_RD, WK_TX_PUSH, WK_RX_POP, WK_RX_WR, WK_WBACK
  } walk_st_e;
endpackage

// File: rtl/chain_dma_regs.sv
module chain_dma_regs
  import chain_dma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  input  logic              ev_tx,
  input  logic              ev_rx,
  input  logic              ev_du,
  output logic              dma_en,
  output logic              swr_pulse,
  output logic              poll_pulse,
  output logic              base_ld,
  output logic [ADDR_W-1:0] base_val,
  output logic [ADDR_W-1:0] base_addr,
  output logic [STS_W-1:0]  sts
);
  logic              en_q, en_d, en_ce;
  logic [ADDR_W-1:0] base_q, base_d;
  logic              base_ce;
  logic [2:0]        stat_q, stat_d, stat_clr;
  logic              mode_wr;

  always_comb begin
    mode_wr    = reg_we && (reg_sel == SEL_MODE);
    swr_pulse  = mode_wr && reg_wdata[MODE_SWR];
    poll_pulse = reg_we && (reg_sel == SEL_POLL);
    base_ld    = reg_we && (reg_sel == SEL_BASE);
    base_val   = reg_wdata[ADDR_W-1:0];
    stat_clr   = (reg_we && (reg_sel == SEL_STAT)) ? reg_wdata[2:0] : 3'b000;

    en_ce   = mode_wr;
    base_ce = base_ld || swr_pulse;
    en_d    = swr_pulse ? 1'b0 : reg_wdata[MODE_EN];
    base_d  = swr_pulse ? '0 : base_val;
    // set wins over a clear in the same cycle
    stat_d  = swr_pulse ? 3'b000 : ((stat_q & ~stat_clr) | {ev_du, ev_rx, ev_tx});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      base_q <= '0;
      stat_q <= 3'b000;
    end else begin
      if (en_ce)   en_q   <= en_d;
      if (base_ce) base_q <= base_d;
      stat_q <= stat_d;
    end
  end

  assign dma_en    = en_q;
  assign base_addr = base_q;
  assign sts       = {stat_q[0] | stat_q[1], stat_q[2], stat_q[1], stat_q[0]};
endmodule

// File: rtl/chain_dma_step.sv
module chain_dma_step
  import chain_dma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              eor,
  input  logic              chn,
  input  logic [ADDR_W-1:0] cur,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] link,
  output logic [ADDR_W-1:0] nxt
);
  always_comb begin
    if (eor)      nxt = base;
    else if (chn) nxt = link;
    else          nxt = cur + ADDR_W'(DESC_BYTES);
  end
endmodule

// File: rtl/chain_dma_walker.sv
module chain_dma_walker
  import chain_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dma_en,
  input  logic              poll,
  input  logic              swr,
  input  logic              base_ld,
  input  logic [ADDR_W-1:0] base_val,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              xfer_tx,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              fifo_wr_valid,
  input  logic              fifo_wr_ready,
  output logic [31:0]       fifo_wr_data,
  input  logic              fifo_rd_valid,
  input  logic [31:0]       fifo_rd_data,
  output logic              fifo_rd_pop,
  output logic              ev_tx,
  output logic              ev_rx,
  output logic              ev_du,
  output logic              busy
);
  localparam int WCNT_W = SIZE_W - 1;

  walk_st_e          st_q, st_d;
  logic [ADDR_W-1:0] cur_q, cur_d, buf_q, buf_d, link_q, link_d, nxt_ptr;
  logic [31:0]       ctl_q, ctl_d, data_q, data_d;
  logic [WCNT_W-1:0] words_q, words_d, widx_q, widx_d, widx_inc;
  logic              dir_q, dir_d;
  logic [SIZE_W:0]   bytes_rnd;
  logic [ADDR_W-1:0] data_addr;
  logic              irq_ok;

  chain_dma_step #(.ADDR_W(ADDR_W)) u_step (
    .eor  (ctl_q[CTL_EOR]),
    .chn  (ctl_q[CTL_CHN]),
    .cur  (cur_q),
    .base (base_addr),
    .link (link_q),
    .nxt  (nxt_ptr)
  );

  always_comb begin
    st_d = st_q;   cur_d = cur_q;     ctl_d = ctl_q;   words_d = words_q;
    buf_d = buf_q; link_d = link_q;   widx_d = widx_q; data_d = data_q;
    dir_d = dir_q;
    mem_req = 1'b0; mem_we = 1'b0; mem_addr = cur_q; mem_wdata = '0;
    fifo_wr_valid = 1'b0; fifo_wr_data = data_q; fifo_rd_pop = 1'b0;
    ev_tx = 1'b0; ev_rx = 1'b0; ev_du = 1'b0;

    widx_inc  = widx_q + 1'b1;
    bytes_rnd = {1'b0, mem_rdata[SIZE_W-1:0]} + (SIZE_W+1)'(3);
    data_addr = buf_q + ADDR_W'({widx_q, 2'b00});
    irq_ok    = ctl_q[CTL_LS] || !ctl_q[CTL_DIC];

    case (st_q)
      WK_IDLE: begin
        if (poll && dma_en) begin
          st_d  = WK_CTRL;
          dir_d = xfer_tx;
        end
      end
      WK_CTRL: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          ctl_d = mem_rdata;
          if (!mem_rdata[CTL_OWN]) begin
            ev_du = 1'b1;
            st_d  = WK_IDLE;
          end else begin
            st_d = WK_SIZE;
          end
        end
      end
      WK_SIZE: begin
        mem_req  = 1'b1;
        mem_addr = cur_q + ADDR_W'(4);
        if (mem_ack) begin
          words_d = bytes_rnd[SIZE_W:2];
          st_d    = WK_BUF;
        end
      end
      WK_BUF: begin
        mem_req  = 1'b1;
        mem_addr = cur_q + ADDR_W'(8);
        if (mem_ack) begin
          buf_d = mem_rdata[ADDR_W-1:0];
          st_d  = WK_LINK;
        end
      end
      WK_LINK: begin
        mem_req  = 1'b1;
        mem_addr = cur_q + ADDR_W'(12);
        if (mem_ack) begin
          link_d = mem_rdata[ADDR_W-1:0];
          widx_d = '0;
          if (words_q == '0) st_d = WK_WBACK;
          else if (dir_q)    st_d = WK_TX_RD;
          else               st_d = WK_RX_POP;
        end
      end
      WK_TX_RD: begin
        mem_req  = 1'b1;
        mem_addr = data_addr;
        if (mem_ack) begin
          data_d = mem_rdata;
          st_d   = WK_TX_PUSH;
        end
      end
      WK_TX_PUSH: begin
        fifo_wr_valid = 1'b1;
        if (fifo_wr_ready) begin
          widx_d = widx_inc;
          st_d   = (widx_inc == words_q) ? WK_WBACK : WK_TX_RD;
        end
      end
      WK_RX_POP: begin
        fifo_rd_pop = fifo_rd_valid;
        if (fifo_rd_valid) begin
          data_d = fifo_rd_data;
          st_d   = WK_RX_WR;
        end
      end
      WK_RX_WR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = data_addr;
        mem_wdata = data_q;
        if (mem_ack) begin
          widx_d = widx_inc;
          st_d   = (widx_inc == words_q) ? WK_WBACK : WK_RX_POP;
        end
      end
      WK_WBACK: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = ctl_q & ~(32'h1 << CTL_OWN);
        if (mem_ack) begin
          cur_d = nxt_ptr;
          ev_tx = irq_ok && dir_q;
          ev_rx = irq_ok && !dir_q;
          st_d  = ctl_q[CTL_LS] ? WK_IDLE : WK_CTRL;
        end
      end
      default: st_d = WK_IDLE;
    endcase

    if (base_ld) cur_d = base_val;
    if (swr) begin
      st_d  = WK_IDLE;
      cur_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= WK_IDLE;
      cur_q   <= '0;
      ctl_q   <= '0;
      words_q <= '0;
      buf_q   <= '0;
      link_q  <= '0;
      widx_q  <= '0;
      data_q  <= '0;
      dir_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      cur_q   <= cur_d;
      ctl_q   <= ctl_d;
      words_q <= words_d;
      buf_q   <= buf_d;
      link_q  <= link_d;
      widx_q  <= widx_d;
      data_q  <= data_d;
      dir_q   <= dir_d;
    end
  end

  assign busy = (st_q != WK_IDLE);
endmodule

// File: rtl/chain_dma.sv
module chain_dma
  import chain_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [31:0]       reg_wdata,
  input  logic              xfer_tx,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              fifo_wr_valid,
  input  logic              fifo_wr_ready,
  output logic [31:0]       fifo_wr_data,
  input  logic              fifo_rd_valid,
  input  logic [31:0]       fifo_rd_data,
  output logic              fifo_rd_pop,
  output logic [STS_W-1:0]  dma_sts,
  output logic              dma_busy
);
  logic [1:0]        rs_q;
  logic              rst_core_n;
  logic              dma_en, swr_pulse, poll_pulse, base_ld;
  logic [ADDR_W-1:0] base_val, base_addr;
  logic              ev_tx, ev_rx, ev_du;

  // assert asynchronously, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  chain_dma_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .reg_we     (reg_we),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .ev_tx      (ev_tx),
    .ev_rx      (ev_rx),
    .ev_du      (ev_du),
    .dma_en     (dma_en),
    .swr_pulse  (swr_pulse),
    .poll_pulse (poll_pulse),
    .base_ld    (base_ld),
    .base_val   (base_val),
    .base_addr  (base_addr),
    .sts        (dma_sts)
  );

  chain_dma_walker #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_walker (
    .clk           (clk),
    .rst_n         (rst_core_n),
    .dma_en        (dma_en),
    .poll          (poll_pulse),
    .swr           (swr_pulse),
    .base_ld       (base_ld),
    .base_val      (base_val),
    .base_addr     (base_addr),
    .xfer_tx       (xfer_tx),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .mem_ack       (mem_ack),
    .mem_rdata     (mem_rdata),
    .fifo_wr_valid (fifo_wr_valid),
    .fifo_wr_ready (fifo_wr_ready),
    .fifo_wr_data  (fifo_wr_data),
    .fifo_rd_valid (fifo_rd_valid),
    .fifo_rd_data  (fifo_rd_data),
    .fifo_rd_pop   (fifo_rd_pop),
    .ev_tx         (ev_tx),
    .ev_rx         (ev_rx),
    .ev_du         (ev_du),
    .busy          (dma_busy)
  );
endmodule

// File: rtl/chain_dma_chk.sv
module chain_dma_chk
  import chain_dma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              dma_en,
  input logic              swr,
  input logic [STS_W-1:0]  sts,
  input logic              mem_req,
  input logic              mem_ack,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              fifo_wr_valid,
  input logic              fifo_wr_ready,
  input logic [31:0]       fifo_wr_data,
  input logic              fifo_rd_pop
);
  p_quiet_when_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !fifo_wr_valid && !fifo_rd_pop));

  p_poll_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !dma_en) |=> !busy);

  p_one_direction_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_wr_valid && fifo_rd_pop));

  p_abort_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
    swr |=> (!busy && sts == '0));

  p_req_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !swr) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  p_push_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr_valid && !fifo_wr_ready && !swr) |=> (fifo_wr_valid && $stable(fifo_wr_data)));
endmodule

bind chain_dma chain_dma_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_core_n),
  .busy          (dma_busy),
  .dma_en        (dma_en),
  .swr           (swr_pulse),
  .sts           (dma_sts),
  .mem_req       (mem_req),
  .mem_ack       (mem_ack),
  .mem_we        (mem_we),
  .mem_addr      (mem_addr),
  .fifo_wr_valid (fifo_wr_valid),
  .fifo_wr_ready (fifo_wr_ready),
  .fifo_wr_data  (fifo_wr_data),
  .fifo_rd_pop   (fifo_rd_pop)
);

// File: tb/chain_dma_bench.sv
module chain_dma_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic        xfer_tx = 1'b1;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = 32'd0;
  logic        fifo_wr_valid;
  logic        fifo_wr_ready = 1'b1;
  logic [31:0] fifo_wr_data;
  logic        fifo_rd_valid = 1'b0;
  logic [31:0] fifo_rd_data = 32'd0;
  logic        fifo_rd_pop;
  logic [3:0]  dma_sts;
  logic        dma_busy;

  always #5 clk = ~clk;

  chain_dma u_chain_dma (.*);

  logic [31:0] mem [0:1023];
  logic [31:0] rlog [0:63];
  int          rcnt = 0;
  logic [31:0] txlog [0:63];
  int          txn = 0;
  logic [31:0] rxq [0:7];
  int          rx_n = 0, rx_i = 0;
  bit          rx_pend = 0;
  int          bp_mode = 0;
  int          gcnt = 0;
  int          checks = 0, errs = 0;
  bit          done = 0;

  // memory, FIFO sink and FIFO source models
  always @(negedge clk) begin
    gcnt++;
    if (rx_pend) begin rx_i++; rx_pend = 0; end
    fifo_wr_ready = (bp_mode == 0) ? 1'b1 : (bp_mode == 1) ? gcnt[1] : 1'b0;
    fifo_rd_valid = (rx_i < rx_n) && ((bp_mode == 0) || gcnt[1]);
    fifo_rd_data  = (rx_i < rx_n) ? rxq[rx_i] : 32'd0;
    #1;
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      if (mem_we) mem[mem_addr[11:2]] = mem_wdata;
      else begin
        mem_rdata = mem[mem_addr[11:2]];
        if (rcnt < 64) rlog[rcnt] = mem_addr;
        rcnt++;
      end
      mem_ack = 1'b1;
    end
    if (fifo_wr_valid && fifo_wr_ready) begin
      if (txn < 64) txlog[txn] = fifo_wr_data;
      txn++;
    end
    if (fifo_rd_pop && fifo_rd_valid) rx_pend = 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] s, input logic [31:0] v);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = s; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (dma_busy && n < 5000) begin @(negedge clk); n++; end
    if (n >= 5000) chk({req, " walk did not end"}, 32'd1, 32'd0);
  endtask

  task automatic t_reset;
    chk("R1 busy", {31'd0, dma_busy}, 32'd0);
    chk("R1 status", {28'd0, dma_sts}, 32'd0);
    chk("R1 request", {31'd0, mem_req}, 32'd0);
  endtask

  task automatic t_tx_chain;
    mem[32'h100>>2] = 32'h8000_001A; mem[32'h104>>2] = 32'hABCD_0008;
    mem[32'h108>>2] = 32'h400;       mem[32'h10C>>2] = 32'h200;
    mem[32'h200>>2] = 32'h8000_0004; mem[32'h204>>2] = 32'h6;
    mem[32'h208>>2] = 32'h500;       mem[32'h20C>>2] = 32'h300;
    mem[32'h400>>2] = 32'h1111_1111; mem[32'h404>>2] = 32'h2222_2222;
    mem[32'h500>>2] = 32'h3333_3333; mem[32'h504>>2] = 32'h4444_4444;
    mem[32'h210>>2] = 32'h0;
    bp_mode = 1; xfer_tx = 1'b1; rcnt = 0; txn = 0;
    wr_reg(2'd1, 32'h100);
    wr_reg(2'd0, 32'h1);
    wr_reg(2'd2, 32'h0);
    wait_idle("R2");
    chk("R2 fetch word 0", rlog[0], 32'h100);
    chk("R2 fetch word 1", rlog[1], 32'h104);
    chk("R2 fetch word 2", rlog[2], 32'h108);
    chk("R2 fetch word 3", rlog[3], 32'h10C);
    chk("R7 chained link", rlog[6], 32'h200);
    chk("R4 push count", txn, 32'd4);
    chk("R4 push 0", txlog[0], 32'h1111_1111);
    chk("R4 push 1", txlog[1], 32'h2222_2222);
    chk("R4 push 2", txlog[2], 32'h3333_3333);
    chk("R14 push 3 under backpressure", txlog[3], 32'h4444_4444);
    chk("R6 writeback A", mem[32'h100>>2], 32'h0000_001A);
    chk("R6 writeback B", mem[32'h200>>2], 32'h0000_0004);
    chk("R8 tx status", {28'd0, dma_sts}, 32'h9);
    rcnt = 0;
    wr_reg(2'd2, 32'h0);
    wait_idle("R8");
    chk("R8 resume address", rlog[0], 32'h210);
    chk("R9 single fetch", rcnt, 32'd1);
    chk("R9 unavailable status", {28'd0, dma_sts}, 32'hD);
    chk("R9 no data", txn, 32'd4);
  endtask

  task automatic t_w1c;
    wr_reg(2'd3, 32'h1);
    chk("R11 clear tx only", {28'd0, dma_sts}, 32'h4);
    wr_reg(2'd3, 32'h0);
    chk("R11 zero write keeps", {28'd0, dma_sts}, 32'h4);
    wr_reg(2'd3, 32'h4);
    chk("R11 clear unavailable", {28'd0, dma_sts}, 32'h0);
  endtask

  task automatic t_refetch;
    mem[32'h800>>2] = 32'h8000_0010; mem[32'h804>>2] = 32'h4;
    mem[32'h808>>2] = 32'h900;       mem[32'h80C>>2] = 32'h840;
    mem[32'h840>>2] = 32'h0;         mem[32'h844>>2] = 32'h4;
    mem[32'h848>>2] = 32'h940;       mem[32'h84C>>2] = 32'h880;
    mem[32'h900>>2] = 32'h5555_5555; mem[32'h940>>2] = 32'h6666_6666;
    bp_mode = 0; txn = 0;
    wr_reg(2'd1, 32'h800);
    wr_reg(2'd2, 32'h0);
    wait_idle("R10");
    chk("R10 completion without last flag", {28'd0, dma_sts}, 32'hD);
    chk("R9 data before stall", txn, 32'd1);
    mem[32'h840>>2] = 32'h8000_0004;
    wr_reg(2'd3, 32'hF);
    rcnt = 0;
    wr_reg(2'd2, 32'h0);
    wait_idle("R9");
    chk("R9 refetch same descriptor", rlog[0], 32'h840);
    chk("R9 data after refetch", txlog[1], 32'h6666_6666);
    chk("R9 status after refetch", {28'd0, dma_sts}, 32'h9);
  endtask

  task automatic t_ring;
    mem[32'hA00>>2] = 32'h8000_0002; mem[32'hA04>>2] = 32'h0000_F000;
    mem[32'hA08>>2] = 32'hB00;       mem[32'hA0C>>2] = 32'hFFC;
    mem[32'hA10>>2] = 32'h8000_0032; mem[32'hA14>>2] = 32'h0;
    mem[32'hA18>>2] = 32'hB40;       mem[32'hA1C>>2] = 32'hC00;
    wr_reg(2'd3, 32'hF);
    rcnt = 0; txn = 0;
    wr_reg(2'd1, 32'hA00);
    wr_reg(2'd2, 32'h0);
    wait_idle("R7");
    chk("R7 increment by 16", rlog[4], 32'hA10);
    chk("R7 end of ring to base", rlog[8], 32'hA00);
    chk("R7 read count", rcnt, 32'd9);
    chk("R13 no data moved", txn, 32'd0);
    chk("R13 writeback E", mem[32'hA00>>2], 32'h0000_0002);
    chk("R6 writeback F", mem[32'hA10>>2], 32'h0000_0032);
    chk("R10 suppressed completion", {28'd0, dma_sts}, 32'h4);
  endtask

  task automatic t_rx;
    mem[32'hC00>>2] = 32'h8000_000C; mem[32'hC04>>2] = 32'd10;
    mem[32'hC08>>2] = 32'hD00;       mem[32'hC0C>>2] = 32'h0;
    mem[32'hD0C>>2] = 32'hDEAD_BEEF;
    rxq[0] = 32'hA1A1_0001; rxq[1] = 32'hA2A2_0002; rxq[2] = 32'hA3A3_0003;
    wr_reg(2'd3, 32'hF);
    bp_mode = 1; xfer_tx = 1'b0;
    rx_i = 0; rx_n = 3;
    wr_reg(2'd1, 32'hC00);
    wr_reg(2'd2, 32'h0);
    wait_idle("R5");
    chk("R5 word 0", mem[32'hD00>>2], 32'hA1A1_0001);
    chk("R5 word 1", mem[32'hD04>>2], 32'hA2A2_0002);
    chk("R5 word 2", mem[32'hD08>>2], 32'hA3A3_0003);
    chk("R5 no overrun", mem[32'hD0C>>2], 32'hDEAD_BEEF);
    chk("R5 all popped", rx_i, 32'd3);
    chk("R10 rx status", {28'd0, dma_sts}, 32'hA);
    chk("R6 rx writeback", mem[32'hC00>>2], 32'h0000_000C);
  endtask

  task automatic t_disabled;
    wr_reg(2'd0, 32'h0);
    rcnt = 0;
    wr_reg(2'd2, 32'h0);
    repeat (20) @(negedge clk);
    chk("R3 stays idle", {31'd0, dma_busy}, 32'd0);
    chk("R3 no fetch", rcnt, 32'd0);
  endtask

  task automatic t_swreset;
    mem[32'hE00>>2] = 32'h8000_0004; mem[32'hE04>>2] = 32'h4;
    mem[32'hE08>>2] = 32'hF00;       mem[32'hE0C>>2] = 32'h0;
    mem[32'h000>>2] = 32'h0;
    bp_mode = 2; xfer_tx = 1'b1;
    wr_reg(2'd0, 32'h1);
    wr_reg(2'd1, 32'hE00);
    wr_reg(2'd2, 32'h0);
    repeat (30) @(negedge clk);
    chk("R14 stalled push", {31'd0, fifo_wr_valid}, 32'd1);
    wr_reg(2'd0, 32'h2);
    chk("R12 abort idle", {31'd0, dma_busy}, 32'd0);
    chk("R12 status cleared", {28'd0, dma_sts}, 32'h0);
    chk("R12 no request", {31'd0, mem_req}, 32'd0);
    chk("R12 no writeback", mem[32'hE00>>2], 32'h8000_0004);
    rcnt = 0;
    wr_reg(2'd2, 32'h0);
    repeat (10) @(negedge clk);
    chk("R12 enable cleared", rcnt, 32'd0);
    bp_mode = 0;
    wr_reg(2'd0, 32'h1);
    wr_reg(2'd2, 32'h0);
    wait_idle("R12");
    chk("R12 pointer cleared", rlog[0], 32'h0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset;
    t_tx_chain;
    t_w1c;
    t_refetch;
    t_ring;
    t_rx;
    t_disabled;
    t_swreset;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errs++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule